// File: doc/BRIEF.md
# Bit-Banged SPI Expander Sequencer

This block turns one SPI word into the series of byte writes that an I2C-controlled 8-bit output port needs in order to imitate an SPI transmitter on three of its pins. A start strobe captures the word, the port's 7-bit device address and a framing option. The block then hands one write at a time to a downstream I2C byte master through a request/acknowledge handshake. Each write carries the device address and one full 8-pin image.

Every SPI bit becomes three images on the port, with SCK going low, then high, then low. Chip select sits on pin 7, data on pin 6 and clock on pin 5, and every other pin stays at 0. When framing is enabled, one extra write before the word drives a separate select pin low, and one after it drives that pin high. A 16-bit word therefore costs 48 data writes, or 50 with framing.

Top module: `spi_port_seq`

## Requirements
- R1: After reset, wr_req, busy, done and err are all 0.
- R2: Every write presents on wr_addr the dev_addr value captured at the accepted start.
- R3: Word bits go out MSB first. A 0 bit is the image sequence 0x00, 0x20, 0x00 (bit 6 SDI low, bit 5 SCK low, high, low). A 1 bit is 0x40, 0x60, 0x40. Bit 7 (CS) and bits 4..0 are 0 in every bit image.
- R4: Without framing, a 16-bit word produces exactly 48 writes.
- R5: With frame_en captured high, the first write is 0x00 (select pin, bit 3, low). The last write is 0x08 (bit 3 high). The total is 50 writes.
- R6: wr_req stays high with wr_data and wr_addr stable until wr_ack is seen. The next write is presented the cycle after an acknowledged write.
- R7: done pulses for exactly one cycle, in the cycle after the final write is acknowledged without NACK, and wr_req and busy are 0 in that cycle.
- R8: wr_ack together with wr_nack aborts the sequence. In the next cycle wr_req is 0, done stays 0 and err is 1. err stays 1 until the next accepted start, which clears it.
- R9: A start pulse while busy is ignored, and the stream in progress is unchanged.
- R10: Changes on word_in, dev_addr and frame_en after an accepted start do not affect the stream in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start strobe, accepted only when idle |
| frame_en | input | 1 | Add the opening and closing select writes |
| word_in | input | WORD_W | SPI word to serialise |
| dev_addr | input | ADDR_W | I2C address of the output port |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Sticky abort flag after a NACK |
| wr_req | output | 1 | Write request to the byte master |
| wr_addr | output | ADDR_W | Device address of the current write |
| wr_data | output | 8 | Pin image of the current write |
| wr_ack | input | 1 | Byte master finished the current write |
| wr_nack | input | 1 | Qualifies wr_ack: the port did not acknowledge |

## Verification
The assertions check the cycle-level rules on every cycle:
- the request holds with stable payload while it waits for an acknowledge;
- a NACK produces an abort with err set;
- err stays set once raised;
- done is a single-cycle pulse with the request low;
- an image with SCK high never carries chip select or stray pins.

Only the bench scenarios can show the following, because they compare each write against an image sequence computed from the word:
- the exact write count;
- MSB-first ordering;
- the framing writes at both ends;
- start pulses and input changes during a run being ignored.

// File: rtl/seq_pkg.sv
package seq_pkg;
    localparam int PIN_CS  = 7;
    localparam int PIN_SDI = 6;
    localparam int PIN_SCK = 5;
    localparam int SUB_PER_BIT = 3;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_OPEN  = 2'd1,
        PH_BITS  = 2'd2,
        PH_CLOSE = 2'd3
    } phase_e;
endpackage

// File: rtl/seq_image.sv
module seq_image
    import seq_pkg::*;
#(
    parameter int FRAME_BIT = 3
) (
    input  phase_e     phase,
    input  logic       sdi,
    input  logic [1:0] sub,
    output logic [7:0] img
);
    always_comb begin
        img = 8'h00;
        case (phase)
            PH_OPEN:  img = 8'h00;
            PH_CLOSE: img[FRAME_BIT] = 1'b1;
            PH_BITS: begin
                img[PIN_SDI] = sdi;
                img[PIN_SCK] = (sub == 2'd1);
            end
            default:  img = 8'h00;
        endcase
    end
endmodule

// File: rtl/seq_step.sv
module seq_step #(
    parameter int WORD_W = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clear,
    input  logic       adv,
    output logic [1:0] sub_o,
    output logic       bit_last_o
);
    localparam int CW = (WORD_W > 1) ? $clog2(WORD_W) : 1;

    typedef struct packed {
        logic [1:0]    sub;
        logic [CW-1:0] cnt;
    } step_t;

    step_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (clear) begin
            s_d = '0;
        end else if (adv) begin
            if (s_q.sub == 2'd2) begin
                s_d.sub = 2'd0;
                s_d.cnt = s_q.cnt + 1'b1;
            end else begin
                s_d.sub = s_q.sub + 2'd1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign sub_o      = s_q.sub;
    assign bit_last_o = (s_q.cnt == CW'(WORD_W - 1)) && (s_q.sub == 2'd2);

    AST_SUB_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.sub != 2'd3); // R3
endmodule

// File: rtl/spi_port_seq.sv
module spi_port_seq
    import seq_pkg::*;
#(
    parameter int WORD_W    = 16,
    parameter int ADDR_W    = 7,
    parameter int FRAME_BIT = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              frame_en,
    input  logic [WORD_W-1:0] word_in,
    input  logic [ADDR_W-1:0] dev_addr,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic              wr_req,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [7:0]        wr_data,
    input  logic              wr_ack,
    input  logic              wr_nack
);
    typedef struct packed {
        phase_e            phase;
        logic [WORD_W-1:0] shreg;
        logic [ADDR_W-1:0] addr;
        logic              frame;
        logic              done;
        logic              err;
    } st_t;

    st_t        st_d, st_q;
    logic       step_clr, step_adv;
    logic [1:0] sub;
    logic       bit_last;

    seq_step #(.WORD_W(WORD_W)) u_step (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (step_clr),
        .adv       (step_adv),
        .sub_o     (sub),
        .bit_last_o(bit_last)
    );

    seq_image #(.FRAME_BIT(FRAME_BIT)) u_img (
        .phase(st_q.phase),
        .sdi  (st_q.shreg[WORD_W-1]),
        .sub  (sub),
        .img  (wr_data)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        step_clr  = 1'b0;
        step_adv  = 1'b0;
        if (st_q.phase == PH_IDLE) begin
            if (start) begin
                st_d.shreg = word_in;
                st_d.addr  = dev_addr;
                st_d.frame = frame_en;
                st_d.err   = 1'b0;
                st_d.phase = frame_en ? PH_OPEN : PH_BITS;
                step_clr   = 1'b1;
            end
        end else if (wr_ack) begin
            if (wr_nack) begin
                st_d.phase = PH_IDLE;
                st_d.err   = 1'b1;
            end else begin
                case (st_q.phase)
                    PH_OPEN: st_d.phase = PH_BITS;
                    PH_BITS: begin
                        step_adv = 1'b1;
                        if (sub == 2'd2) st_d.shreg = st_q.shreg << 1;
                        if (bit_last) begin
                            if (st_q.frame) begin
                                st_d.phase = PH_CLOSE;
                            end else begin
                                st_d.phase = PH_IDLE;
                                st_d.done  = 1'b1;
                            end
                        end
                    end
                    PH_CLOSE: begin
                        st_d.phase = PH_IDLE;
                        st_d.done  = 1'b1;
                    end
                    default: st_d.phase = PH_IDLE;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.phase <= PH_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    assign wr_req  = (st_q.phase != PH_IDLE);
    assign busy    = wr_req;
    assign wr_addr = st_q.addr;
    assign done    = st_q.done;
    assign err     = st_q.err;

    AST_HOLD_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req && !wr_ack |=> wr_req && $stable(wr_data) && $stable(wr_addr)); // R6
    AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req && $past(wr_req) |-> $stable(wr_addr)); // R2
    AST_NACK_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req && wr_ack && wr_nack |=> err && !wr_req && !done); // R8
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        err && !(start && !busy) |=> err); // R8
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !wr_req && !busy); // R7
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R7
    AST_SCK_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req && wr_data[PIN_SCK] |-> !wr_data[PIN_CS] && (wr_data[4:0] == 5'd0)); // R3
endmodule

// File: tb/sim_spi_port_seq.sv
module sim_spi_port_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        frame_en = 1'b0;
    logic [15:0] word_in = '0;
    logic [6:0]  dev_addr = '0;
    logic        busy, done, err, wr_req;
    logic [6:0]  wr_addr;
    logic [7:0]  wr_data;
    logic        wr_ack = 1'b0;
    logic        wr_nack = 1'b0;

    int errors = 0;
    int checks = 0;
    int cyc = 0;

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    spi_port_seq u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .frame_en(frame_en),
        .word_in(word_in), .dev_addr(dev_addr), .busy(busy), .done(done),
        .err(err), .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data),
        .wr_ack(wr_ack), .wr_nack(wr_nack)
    );

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, expv);
        end
    endtask

    function automatic logic [7:0] exp_img(input logic [15:0] w, input bit frm,
                                           input int k, input int total);
        int j;
        logic [7:0] v;
        if (frm && k == 0) return 8'h00;
        if (frm && k == total - 1) return 8'h08;
        j = k - (frm ? 1 : 0);
        v = 8'h00;
        if (w[15 - j / 3]) v = v | 8'h40;
        if (j % 3 == 1)    v = v | 8'h20;
        return v;
    endfunction

    task automatic run_word(input logic [15:0] w, input logic [6:0] a, input bit frm,
                            input int lat, input int nack_at, input bit poke);
        int total = 48 + (frm ? 2 : 0);
        int k = 0;
        bit fin = 0;
        logic [7:0] held;
        word_in = w; dev_addr = a; frame_en = frm;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        chk(busy && !err, "R8 start clears err / busy", {busy, err}, 2'b10);
        while (!fin && k < 60) begin
            if (!wr_req) begin
                chk(0, "R6 request present", 0, 1);
                fin = 1;
            end else begin
                if (k == 0) begin
                    word_in = ~w; dev_addr = a ^ 7'h2a; frame_en = ~frm; // R10
                end
                if (poke && k == 5) begin
                    start = 1'b1; // R9
                    @(negedge clk) start = 1'b0;
                end
                held = wr_data;
                for (int i = 0; i < lat; i++) begin
                    @(negedge clk);
                    if (wr_data != held || !wr_req)
                        chk(0, "R6 hold while waiting", wr_data, held);
                end
                chk(wr_data == exp_img(w, frm, k, total),
                    (frm && (k == 0 || k == total - 1)) ? "R5 framing image" : "R3 bit image",
                    wr_data, exp_img(w, frm, k, total));
                chk(wr_addr == a, "R2 address", wr_addr, a);
                wr_ack = 1'b1; wr_nack = (k == nack_at);
                @(negedge clk) begin wr_ack = 1'b0; wr_nack = 1'b0; end
                if (k == nack_at) begin
                    chk(!wr_req && err && !done, "R8 abort", {wr_req, err, done}, 3'b010);
                    repeat (4) @(negedge clk);
                    chk(!wr_req && err && !busy, "R8 stays aborted", {wr_req, err, busy}, 3'b010);
                    fin = 1;
                end else if (k == total - 1) begin
                    chk(done && !wr_req && !busy, "R7 done pulse", {done, wr_req, busy}, 3'b100);
                    chk(k + 1 == total, frm ? "R5 write count" : "R4 write count", k + 1, total);
                    @(negedge clk);
                    chk(!done, "R7 done single cycle", done, 0);
                    fin = 1;
                end else begin
                    if (done) chk(0, "R7 early done", done, 0);
                    k++;
                end
            end
        end
    endtask

    initial begin
        logic [15:0] words [8] = '{16'h0000, 16'hFFFF, 16'hA55A, 16'h8400,
                                   16'h0001, 16'h8000, 16'h5AA5, 16'h1234};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!wr_req && !busy && !done && !err, "R1 reset state",
            {wr_req, busy, done, err}, 0);
        for (int i = 0; i < 8; i++)
            for (int f = 0; f < 2; f++)
                run_word(words[i], 7'(7'h20 + i), f[0], (i + f) % 4, -1, 1'b0);
        run_word(16'hC3A1, 7'h11, 1'b1, 2, -1, 1'b1);
        run_word(16'h0F0F, 7'h12, 1'b1, 1, 0, 1'b0);
        run_word(16'hFFFF, 7'h13, 1'b0, 0, 20, 1'b0);
        run_word(16'h8001, 7'h14, 1'b1, 1, 49, 1'b0);
        run_word(16'h6C3B, 7'h15, 1'b0, 3, -1, 1'b0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        wait (cyc > 150000);
        errors++;
        checks++;
        $display("FAIL watchdog actual=%0d expected<150000", cyc);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule